// File: doc/BRIEF.md
# Stereo Level Limiter with Zero-Cross Gating

This block is the gain-reduction half of a digital automatic level control for a stereo audio stream. One sample pair arrives per sample strobe. The block picks either the recording or the playback pair, scales each channel by its current volume code, and compares the scaled magnitudes against one of four selectable ceilings. When either channel reaches the ceiling, a single shared volume target is lowered by a programmable number of 0.375 dB codes.

Each channel then moves to the new target on its own. With zero-cross gating on, a channel takes the new code at the next sample where its waveform crosses zero. If that does not happen in time, a programmable timeout applies it to both channels. With gating off, the change is immediate and fixed at one code. While the level control is disabled, or both converters are powered down, the gains follow a preset volume input. Gain increase (recovery) is outside this block.

Top module: `stereo_level_limiter`

## Requirements
- R1: After reset both gain outputs equal ZERO_DB_CODE and both sample outputs are 0. While `alc_en` is 0, or both `adc_pwr` and `dac_pwr` are 0, every strobed sample loads `vol_preset` into both gains, cancels any pending update and starts no event.
- R2: When only `dac_pwr` is 1, the channels are taken from `play_l`/`play_r`. Otherwise they are taken from `rec_l`/`rec_r`.
- R3: An event fires on a strobed sample when |scaled sample| of either channel is at least T(det_level). T is round(32768·10^(−d/20)) with d = 2.5, 4.1, 6.0 and 8.5 for codes 0, 1, 2 and 3.
- R4: With gating on, an event lowers the shared target by 2^atten_step codes (1, 2, 4 or 8). The target saturates at 0 and never rises while the control is active.
- R5: With gating on, a channel with a pending update takes the target on a later strobed sample where its input is exactly 0 or its sign bit differs from the previous strobed sample. A channel's gain is never below the shared target.
- R6: Pending updates are forced on both channels at the N-th strobed sample after the event. N = 128 << zc_timeout, giving 128, 256, 512 or 1024.
- R7: With `zc_off` = 1, an event lowers the target and both gains by exactly one code, and `atten_step` is ignored. The new gain applies from the next strobed sample.
- R8: No event is accepted on a sample where any channel still has a pending update at the start of that sample.
- R9: The scaled output is floor(x·M[a mod 16] / 2^(15 + a div 16)). Here a = max(0, ZERO_DB_CODE − gain) and M[k] = round(32768·10^(−0.375k/20)).
- R10: Events repeat on successive eligible samples while the level stays at or above the threshold. They stop once it falls below, and resume when it reaches the threshold again.
- R11: Gains and sample outputs change only at a clock edge where `sample_valid` is 1. The sample outputs then carry the scaled value of that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe per sample period |
| rec_l | input | DATA_W | Recording path left sample, signed |
| rec_r | input | DATA_W | Recording path right sample, signed |
| play_l | input | DATA_W | Playback path left sample, signed |
| play_r | input | DATA_W | Playback path right sample, signed |
| alc_en | input | 1 | Level control enable |
| adc_pwr | input | 1 | Recording converter powered |
| dac_pwr | input | 1 | Playback converter powered |
| det_level | input | 2 | Threshold select |
| atten_step | input | 2 | Attenuation step select |
| zc_off | input | 1 | 1 disables zero-cross gating |
| zc_timeout | input | 2 | Zero-cross timeout select |
| vol_preset | input | GAIN_W | Volume code loaded while inactive |
| gain_l | output | GAIN_W | Applied left volume code |
| gain_r | output | GAIN_W | Applied right volume code |
| out_l | output | DATA_W | Gain-scaled left sample |
| out_r | output | DATA_W | Gain-scaled right sample |

## Verification
Two functions can fall on the same sample. A new threshold crossing can arrive while an earlier update is still pending. A channel's own zero crossing can land on the very sample where the timeout forces both channels. The bench provokes the first by holding the left channel constant and loud, so that it crosses the threshold on every sample while its update waits 128, 256 or 1024 samples for the timeout. It provokes the second by driving alternating or zero samples around the timeout. A behavioural per-sample model decides the outcome, and every cycle's gains and outputs are compared against it. Directed checks pin the exact sample at which the forced update lands, and confirm that the crossings ignored meanwhile leave the target unchanged.

// File: rtl/lvl_lim_pkg.sv
// Package: shared constants and elaboration-time conversion helpers for the
// stereo level limiter. The real-valued functions are evaluated only while
// elaborating constant tables; no real arithmetic reaches hardware.
package lvl_lim_pkg;

    // Fraction bits of the linear gain mantissa (unity = 2**MANT_FRAC).
    localparam int MANT_FRAC = 15;
    // Volume codes per factor-of-two coarse shift (16 x 0.375 dB = 6 dB).
    localparam int FINE_W    = 4;
    // Number of selectable detection thresholds.
    localparam int NUM_LVL   = 4;

    // Linear magnitude of a level 'atten_db' below 'full_scale', rounded.
    function automatic int db_to_lin(input real atten_db, input real full_scale);
        return $rtoi(full_scale * (10.0 ** (-atten_db / 20.0)) + 0.5);
    endfunction

    // Attenuation in dB below full scale for each threshold select code.
    function automatic real det_level_db(input int code);
        case (code)
            0:       return 2.5;
            1:       return 4.1;
            2:       return 6.0;
            default: return 8.5;
        endcase
    endfunction

endpackage

// File: rtl/lvl_gain_scaler.sv
// Module: lvl_gain_scaler
// Multiplies one signed sample by the linear gain of a volume code. Codes at
// or above ZERO_DB_CODE are unity; each code below it adds 0.375 dB of cut.
// The cut is split into a fine mantissa (16 entries) and a coarse right shift.
// Assumes: purely combinational, result truncated toward minus infinity.
module lvl_gain_scaler
    import lvl_lim_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int GAIN_W       = 8,
    parameter int ZERO_DB_CODE = 200
)(
    input  logic [GAIN_W-1:0]        gain_code,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] dout,
    output logic [DATA_W-1:0]        dout_mag
);

    localparam int COARSE_W = GAIN_W - FINE_W;
    localparam int MANT_W   = MANT_FRAC + 1;
    localparam int PROD_W   = DATA_W + MANT_W + 1;
    localparam int FINE_N   = 1 << FINE_W;
    localparam logic [GAIN_W-1:0] ZCODE = GAIN_W'(ZERO_DB_CODE);

    logic [MANT_W-1:0]         mant_tbl [FINE_N];
    logic [GAIN_W-1:0]         atten;
    logic [FINE_W-1:0]         fine;
    logic [COARSE_W-1:0]       coarse;
    logic signed [PROD_W-1:0]  prod;
    logic signed [PROD_W-1:0]  shifted;

    // Fine mantissa table, one entry per 0.375 dB step inside a 6 dB span.
    for (genvar k = 0; k < FINE_N; k++) begin : g_mant
        localparam int MV = db_to_lin(0.375 * real'(k), 2.0 ** MANT_FRAC);
        assign mant_tbl[k] = MANT_W'(MV);
    end

    // Attenuation in codes below unity, clamped at zero.
    assign atten  = (gain_code >= ZCODE) ? '0 : ZCODE - gain_code;
    assign fine   = atten[FINE_W-1:0];
    assign coarse = atten[GAIN_W-1:FINE_W];

    // Multiply by the mantissa, then drop fraction bits plus coarse shift.
    always_comb begin
        prod    = PROD_W'(din) * PROD_W'($signed({1'b0, mant_tbl[fine]}));
        shifted = prod >>> (MANT_FRAC + int'(coarse));
    end

    assign dout     = shifted[DATA_W-1:0];
    // Magnitude; the most negative value maps to 2**(DATA_W-1) unsigned.
    assign dout_mag = dout[DATA_W-1] ? $unsigned(-dout) : $unsigned(dout);

endmodule

// File: rtl/lvl_zc_detect.sv
// Module: lvl_zc_detect
// Flags a zero crossing on one channel: the current strobed sample is zero,
// or its sign differs from the sign of the previous strobed sample.
// Assumes: the sign history starts positive after reset.
module lvl_zc_detect #(
    parameter int DATA_W = 16
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic signed [DATA_W-1:0] din,
    output logic                     zc
);

    logic prev_neg;

    // Remember the sign of the last strobed sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_neg <= 1'b0;
        end else if (sample_valid) begin
            prev_neg <= din[DATA_W-1];
        end
    end

    assign zc = (din == '0) || (din[DATA_W-1] != prev_neg);

endmodule

// File: rtl/lvl_limit_ctrl.sv
// Module: lvl_limit_ctrl
// Holds the shared target volume and the per-channel applied volumes. An
// over-threshold sample with no update pending lowers the target. Each channel
// then adopts it at its own zero crossing, at the timeout, or at once when
// gating is off. While inactive all codes follow the preset.
// Assumes: 'over' and 'zc_hit' are valid on sample_valid cycles.
module lvl_limit_ctrl #(
    parameter int GAIN_W        = 8,
    parameter int NCH           = 2,
    parameter int ZERO_DB_CODE  = 200,
    parameter int TMO_BASE_LOG2 = 7
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_valid,
    input  logic                         active,
    input  logic                         over,
    input  logic                         zc_off,
    input  logic [1:0]                   step_sel,
    input  logic [1:0]                   tmo_sel,
    input  logic [GAIN_W-1:0]            vol_preset,
    input  logic [NCH-1:0]               zc_hit,
    output logic [NCH-1:0][GAIN_W-1:0]   gain_app
);

    localparam int CNT_W = TMO_BASE_LOG2 + 3;
    localparam logic [GAIN_W-1:0] ZCODE = GAIN_W'(ZERO_DB_CODE);

    logic [GAIN_W-1:0] target;
    logic [GAIN_W-1:0] step_amt;
    logic [GAIN_W-1:0] next_target;
    logic [CNT_W-1:0]  tmo_cnt;
    logic [CNT_W-1:0]  tmo_last;
    logic [NCH-1:0]    pend;
    logic              pend_any;
    logic              expire;
    logic              fire;

    assign pend_any    = |pend;
    assign tmo_last    = CNT_W'((32'd1 << (TMO_BASE_LOG2 + 32'(tmo_sel))) - 32'd1);
    assign expire      = pend_any && (tmo_cnt == tmo_last);
    assign fire        = active && over && !pend_any;
    assign step_amt    = zc_off ? GAIN_W'(1) : (GAIN_W'(1) << step_sel);
    assign next_target = (target > step_amt) ? (target - step_amt) : '0;

    // Shared target: preset while inactive, lowered by each accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= ZCODE;
        end else if (sample_valid) begin
            if (!active) begin
                target <= vol_preset;
            end else if (fire) begin
                target <= next_target;
            end
        end
    end

    // Timeout counter: counts strobed samples while an update is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_cnt <= '0;
        end else if (sample_valid) begin
            if (!active || fire || expire) begin
                tmo_cnt <= '0;
            end else if (pend_any) begin
                tmo_cnt <= tmo_cnt + 1'b1;
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic              pend_q;
        logic [GAIN_W-1:0] app_q;

        // Per-channel applied code and pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                app_q  <= ZCODE;
            end else if (sample_valid) begin
                if (!active) begin
                    pend_q <= 1'b0;
                    app_q  <= vol_preset;
                end else if (fire) begin
                    if (zc_off) begin
                        app_q <= next_target;
                    end else begin
                        pend_q <= 1'b1;
                    end
                end else if (pend_q && (zc_off || zc_hit[c] || expire)) begin
                    app_q  <= target;
                    pend_q <= 1'b0;
                end
            end
        end

        assign pend[c]     = pend_q;
        assign gain_app[c] = app_q;

        // R5: a channel never sits below the shared target.
        p_applied_not_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
            app_q >= target);
    end

    // R4: the target never rises across a strobed active sample.
    p_target_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && active) |=> (target <= $past(target)));

    // R8: no event is taken while an update is still pending.
    p_hold_while_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && active && pend_any) |=> $stable(target));

    // R7: with gating off an event reaches both channels on the same edge.
    p_immediate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && fire && zc_off) |=>
            ((gain_app[0] == target) && (gain_app[NCH-1] == target) && !pend_any));

    // R6: an expiring timeout leaves nothing pending.
    p_timeout_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && active && expire) |=> !pend_any);

endmodule

// File: rtl/stereo_level_limiter.sv
// Module: stereo_level_limiter (top)
// Selects the recording or playback pair, scales each channel by its applied
// volume code, compares the scaled magnitudes with the selected threshold and
// drives the limiter control. Scaled samples are registered on the strobe.
// Assumes: sample_valid is a single-cycle strobe once per sample period.
module stereo_level_limiter
    import lvl_lim_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int GAIN_W        = 8,
    parameter int ZERO_DB_CODE  = 200,
    parameter int TMO_BASE_LOG2 = 7
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic signed [DATA_W-1:0] rec_l,
    input  logic signed [DATA_W-1:0] rec_r,
    input  logic signed [DATA_W-1:0] play_l,
    input  logic signed [DATA_W-1:0] play_r,
    input  logic                     alc_en,
    input  logic                     adc_pwr,
    input  logic                     dac_pwr,
    input  logic [1:0]               det_level,
    input  logic [1:0]               atten_step,
    input  logic                     zc_off,
    input  logic [1:0]               zc_timeout,
    input  logic [GAIN_W-1:0]        vol_preset,
    output logic [GAIN_W-1:0]        gain_l,
    output logic [GAIN_W-1:0]        gain_r,
    output logic signed [DATA_W-1:0] out_l,
    output logic signed [DATA_W-1:0] out_r
);

    localparam int NCH = 2;

    logic                       active;
    logic                       use_play;
    logic signed [DATA_W-1:0]   ch_in     [NCH];
    logic signed [DATA_W-1:0]   ch_scaled [NCH];
    logic [DATA_W-1:0]          ch_mag    [NCH];
    logic [NCH-1:0]             ch_zc;
    logic [NCH-1:0]             ch_over;
    logic [NCH-1:0][GAIN_W-1:0] ch_gain;
    logic [DATA_W-1:0]          thr_tbl   [NUM_LVL];
    logic [DATA_W-1:0]          thr_sel;
    logic                       over_any;

    // Threshold magnitudes, computed from dB values during elaboration.
    for (genvar t = 0; t < NUM_LVL; t++) begin : g_thr
        localparam int TV = db_to_lin(det_level_db(t), 2.0 ** (DATA_W - 1));
        assign thr_tbl[t] = DATA_W'(TV);
    end

    // Path and activity decode from the converter power flags.
    assign use_play = dac_pwr && !adc_pwr;
    assign active   = alc_en && (adc_pwr || dac_pwr);
    assign ch_in[0] = use_play ? play_l : rec_l;
    assign ch_in[1] = use_play ? play_r : rec_r;
    assign thr_sel  = thr_tbl[det_level];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        lvl_gain_scaler #(
            .DATA_W       (DATA_W),
            .GAIN_W       (GAIN_W),
            .ZERO_DB_CODE (ZERO_DB_CODE)
        ) u_scale (
            .gain_code (ch_gain[c]),
            .din       (ch_in[c]),
            .dout      (ch_scaled[c]),
            .dout_mag  (ch_mag[c])
        );

        lvl_zc_detect #(
            .DATA_W (DATA_W)
        ) u_zc (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_valid (sample_valid),
            .din          (ch_in[c]),
            .zc           (ch_zc[c])
        );

        assign ch_over[c] = (ch_mag[c] >= thr_sel);
    end

    assign over_any = |ch_over;

    lvl_limit_ctrl #(
        .GAIN_W        (GAIN_W),
        .NCH           (NCH),
        .ZERO_DB_CODE  (ZERO_DB_CODE),
        .TMO_BASE_LOG2 (TMO_BASE_LOG2)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .active       (active),
        .over         (over_any),
        .zc_off       (zc_off),
        .step_sel     (atten_step),
        .tmo_sel      (zc_timeout),
        .vol_preset   (vol_preset),
        .zc_hit       (ch_zc),
        .gain_app     (ch_gain)
    );

    // Register the scaled samples once per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_l <= '0;
            out_r <= '0;
        end else if (sample_valid) begin
            out_l <= ch_scaled[0];
            out_r <= ch_scaled[1];
        end
    end

    assign gain_l = ch_gain[0];
    assign gain_r = ch_gain[1];

    // R11: nothing visible moves between strobes.
    p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(out_l) && $stable(out_r) && $stable(gain_l) && $stable(gain_r)));

    // R1: an inactive strobe loads the preset into both gains.
    p_preset_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !active) |=> ((gain_l == $past(vol_preset)) && (gain_r == $past(vol_preset))));

endmodule

// File: tb/stereo_level_limiter_tb.sv
// Bench: per-sample behavioural model compared on every clock, plus directed
// checks at the samples where the requirements fix an exact value.
module stereo_level_limiter_tb;

    localparam int ZDB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_valid = 1'b0;
    logic signed [15:0] rec_l = 0, rec_r = 0, play_l = 0, play_r = 0;
    logic alc_en = 0, adc_pwr = 0, dac_pwr = 0, zc_off = 0;
    logic [1:0] det_level = 0, atten_step = 0, zc_timeout = 0;
    logic [7:0] vol_preset = 8'(ZDB);
    logic [7:0] gain_l, gain_r;
    logic signed [15:0] out_l, out_r;

    int checks = 0;
    int errors = 0;
    bit run_chk = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    stereo_level_limiter #(.ZERO_DB_CODE(ZDB)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .rec_l(rec_l), .rec_r(rec_r), .play_l(play_l), .play_r(play_r),
        .alc_en(alc_en), .adc_pwr(adc_pwr), .dac_pwr(dac_pwr),
        .det_level(det_level), .atten_step(atten_step), .zc_off(zc_off),
        .zc_timeout(zc_timeout), .vol_preset(vol_preset),
        .gain_l(gain_l), .gain_r(gain_r), .out_l(out_l), .out_r(out_r)
    );

    // Reference tables from the dB definitions in the requirements.
    int mtab [16];
    int ttab [4];
    function automatic int lin(real db);
        return $rtoi(32768.0 * (10.0 ** (-db / 20.0)) + 0.5);
    endfunction
    initial begin
        for (int k = 0; k < 16; k++) mtab[k] = lin(0.375 * k);
        ttab[0] = lin(2.5); ttab[1] = lin(4.1); ttab[2] = lin(6.0); ttab[3] = lin(8.5);
    end

    // Model state.
    int m_target = ZDB;
    int m_app [2] = '{ZDB, ZDB};
    bit m_pend [2] = '{0, 0};
    bit m_neg [2] = '{0, 0};
    int m_cnt = 0;
    int m_out [2] = '{0, 0};

    task automatic model_step();
        int x [2];
        int o [2];
        bit zc [2];
        bit over, act, pany, exp_now, fire;
        int stepv, nt;
        act = alc_en && (adc_pwr || dac_pwr);
        if (dac_pwr && !adc_pwr) begin x[0] = play_l; x[1] = play_r; end
        else begin x[0] = rec_l; x[1] = rec_r; end
        over = 0;
        for (int c = 0; c < 2; c++) begin
            int a;
            longint p;
            a = (m_app[c] >= ZDB) ? 0 : ZDB - m_app[c];
            p = (longint'(x[c]) * longint'(mtab[a % 16])) >>> (15 + a / 16);
            o[c] = int'(p);
            if (((o[c] < 0) ? -o[c] : o[c]) >= ttab[det_level]) over = 1;
            zc[c] = (x[c] == 0) || ((x[c] < 0) != m_neg[c]);
            m_neg[c] = (x[c] < 0);
        end
        if (!act) begin
            m_target = vol_preset;
            for (int c = 0; c < 2; c++) begin m_app[c] = vol_preset; m_pend[c] = 0; end
            m_cnt = 0;
        end else begin
            pany = m_pend[0] || m_pend[1];
            exp_now = pany && (m_cnt == (128 << zc_timeout) - 1);
            fire = over && !pany;
            stepv = zc_off ? 1 : (1 << atten_step);
            nt = (m_target > stepv) ? m_target - stepv : 0;
            if (fire) begin
                m_target = nt;
                for (int c = 0; c < 2; c++) begin
                    if (zc_off) m_app[c] = nt; else m_pend[c] = 1;
                end
                m_cnt = 0;
            end else begin
                for (int c = 0; c < 2; c++)
                    if (m_pend[c] && (zc_off || zc[c] || exp_now)) begin
                        m_app[c] = m_target; m_pend[c] = 0;
                    end
                if (exp_now) m_cnt = 0; else if (pany) m_cnt++;
            end
        end
        m_out[0] = o[0]; m_out[1] = o[1];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_target = ZDB; m_app = '{ZDB, ZDB}; m_pend = '{0, 0};
            m_neg = '{0, 0}; m_cnt = 0; m_out = '{0, 0};
        end else if (sample_valid) begin
            model_step();
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model (R11 covers the hold cycles).
    always @(negedge clk) begin
        if (run_chk) begin
            chk(cur_req, "gain_l", int'(gain_l), m_app[0]);
            chk(cur_req, "gain_r", int'(gain_r), m_app[1]);
            chk(cur_req, "out_l", int'(out_l), m_out[0]);
            chk(cur_req, "out_r", int'(out_r), m_out[1]);
        end
    end

    task automatic pump(int n);
        repeat (n) begin
            @(negedge clk); sample_valid = 1'b1;
            @(negedge clk); sample_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic reload(int preset);
        alc_en = 0; vol_preset = 8'(preset);
        pump(1);
        alc_en = 1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset gain_l", int'(gain_l), ZDB);
        chk("R1", "reset gain_r", int'(gain_r), ZDB);
        chk("R1", "reset out_l", int'(out_l), 0);
        run_chk = 1;

        // R1 R9 R11: inactive, preset below unity scales the path.
        cur_req = "R1 R9 R11";
        adc_pwr = 1; vol_preset = 5;
        rec_l = 30000; rec_r = -12345; pump(3);
        chk("R1", "preset gain", int'(gain_l), 5);
        rec_l = 1000; rec_r = -500; vol_preset = 8'(ZDB); pump(1);

        // R3 R4 R5 R6 R8: gating on, 2-code step, 128-sample timeout.
        cur_req = "R3 R4 R5 R6 R8";
        alc_en = 1; det_level = 0; atten_step = 1; zc_off = 0; zc_timeout = 0;
        rec_l = 30000;
        for (int i = 1; i <= 129; i++) begin
            rec_r = (i % 2) ? -16'sd20000 : 16'sd20000;
            pump(1);
            if (i == 2) begin
                chk("R5", "right at crossing", int'(gain_r), ZDB - 2);
                chk("R5", "left waits", int'(gain_l), ZDB);
            end
            if (i == 128) chk("R8", "left still pending", int'(gain_l), ZDB);
            if (i == 129) chk("R6", "forced at 128", int'(gain_l), ZDB - 2);
        end
        for (int i = 130; i <= 262; i++) begin
            rec_r = (i % 2) ? -16'sd20000 : 16'sd20000;
            pump(1);
        end
        rec_l = 0; pump(1);
        chk("R5", "left at zero sample", int'(gain_l), ZDB - 6);
        rec_l = 30000; pump(4);

        // R7 R4: gating off, step field ignored, saturation at code 0.
        cur_req = "R7 R4";
        reload(ZDB);
        zc_off = 1; atten_step = 3; det_level = 3;
        rec_l = 32000; rec_r = 32000; pump(1);
        chk("R7", "one code per event", int'(gain_l), ZDB - 1);
        pump(11);
        chk("R4", "saturated", int'(gain_r), 0);

        // R10: repeat while above, stop below, re-arm on a louder sample.
        cur_req = "R10";
        reload(ZDB);
        det_level = 0; rec_l = 30000; rec_r = 100; pump(10);
        chk("R10", "stops below threshold", int'(gain_l), 3);
        rec_l = 1000; pump(3);
        rec_l = 32767; pump(1);
        chk("R10", "re-armed", int'(gain_l), 2);

        // R2: playback only, then both off, then both on.
        cur_req = "R2";
        reload(ZDB);
        adc_pwr = 0; dac_pwr = 1; rec_l = 32000; rec_r = 32000;
        play_l = 100; play_r = -7; pump(6);
        chk("R2", "playback path out", int'(out_l), 100);
        chk("R2", "no event on quiet path", int'(gain_l), ZDB);
        dac_pwr = 0; vol_preset = 6; pump(4);
        chk("R2", "powered down follows preset", int'(gain_r), 6);
        adc_pwr = 1; dac_pwr = 1; vol_preset = 8'(ZDB); reload(ZDB); pump(2);

        // R6 R8: 256 and 1024 sample timeouts, 4-code step, steady loud input.
        cur_req = "R6 R8";
        zc_off = 0; atten_step = 2; zc_timeout = 1; det_level = 0;
        reload(ZDB);
        rec_l = 30000; rec_r = 30000; pump(1);
        pump(255);
        chk("R6", "before 256", int'(gain_l), ZDB);
        pump(1);
        chk("R6", "at 256", int'(gain_l), ZDB - 4);
        zc_timeout = 3;
        reload(ZDB);
        pump(1); pump(1023);
        chk("R8", "before 1024", int'(gain_r), ZDB);
        pump(1);
        chk("R6", "at 1024", int'(gain_r), ZDB - 4);
        pump(3);

        run_chk = 0;
        finish_run();
    end

endmodule